// File: doc/BRIEF.md
# Fractional X/Y Clock-Enable Divider

This block turns a stream of qualified input cycles into a thinner stream of single-cycle enable pulses. The average rate is the qualified input rate scaled by X/Y. X and Y are 8-bit programmable values, with X no larger than Y. A rate-multiplier accumulator spreads the pulses as evenly as the ratio allows. The block never switches a clock net. It raises an enable that downstream logic in the same clock domain uses to gate its registers.

The `src_en` input marks which input cycles count. Tie it high to divide the raw clock. Feed it from another divider's `div_en` to chain two ratios, so the downstream rate is the product of both fractions. An illegal setting blocks all pulses and raises `cfg_err`. An illegal setting is a zero value or X above Y. A changed setting is taken only when the accumulator comes back to exactly zero, so the pulse pattern never breaks mid-period. When parameter `GEN_CLK` is set, a divided square wave `div_clk` is also produced. It flips on every pulse.

Top module: `fractional_xy_div`

## Requirements
- R1: While `rst_n` is low, `div_en`, `div_clk` and `cfg_err` are all 0, whatever the other inputs do.
- R2: With a legal setting where X equals Y, every qualified cycle (`src_en` high) is followed on the next cycle by `div_en` high.
- R3: With a stable legal setting, any Y consecutive qualified cycles yield exactly X pulses on `div_en`.
- R4: A cycle with `src_en` low does not advance the accumulator. `div_en` is high only in the cycle after a qualified cycle.
- R5: If the active X is 0, or the active Y is 0, or X exceeds Y, then `cfg_err` is 1 and no `div_en` pulse is produced.
- R6: While the block is in error, a newly presented setting is taken at the next clock edge. If that setting is legal, `cfg_err` drops to 0 one cycle later and the pulses resume.
- R7: While the block runs with a legal setting, a change on `cfg_x`/`cfg_y` takes effect only on the qualified cycle whose sum equals Y exactly, that is, when the accumulator returns to zero. Until then the old ratio continues.
- R8: When a second divider's `src_en` is driven by a first divider's `div_en`, the second divider's pulse count equals the input count times X1/Y1 times X2/Y2.
- R9: When `GEN_CLK` is 1, `div_clk` changes level exactly on the cycles in which `div_en` is high. After N pulses from reset it equals N mod 2.
- R10: After reset, the setting is taken at the first clock edge and the accumulator starts from zero. The first pulse therefore follows the ceil(Y/X)-th qualified cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 1 | Qualifies the current cycle as one input step |
| cfg_x | input | XW | Numerator X of the rate ratio |
| cfg_y | input | XW | Denominator Y of the rate ratio |
| div_en | output | 1 | Single-cycle output enable pulse |
| div_clk | output | 1 | Square wave that flips on each pulse (0 when GEN_CLK=0) |
| cfg_err | output | 1 | Active setting is illegal and output is held off |

## Verification
The hardest case to reach from the ports is a setting change that lands while the accumulator holds a remainder. The change must not take effect until the sum returns exactly to zero. The stimulus runs a 1/4 ratio for one step, then presents 1/2. If the new setting were taken at once, the pulse would come two steps early. The test checks that the first pulse stays on the fourth step and that the faster rate begins only afterwards. Recovery from an illegal setting is reached the same way: the bench drives an illegal ratio, then writes a legal one while `src_en` stays high.

// File: rtl/xy_div_pkg.sv
package xy_div_pkg;

  // Operating phase of the divider's active setting
  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,  // first edge after reset: setting not yet taken
    PH_RUN   = 2'd1,  // legal setting active, accumulator stepping
    PH_FAULT = 2'd2   // illegal setting active, output held off
  } ph_e;

endpackage

// File: rtl/xy_ratio_gate.sv
module xy_ratio_gate
  import xy_div_pkg::*;
#(
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cfg_x,
  input  logic [XW-1:0] cfg_y,
  input  logic          wrap_i,
  output logic [XW-1:0] act_x,
  output logic [XW-1:0] act_y,
  output ph_e           phase,
  output logic          load_o
);

  logic [XW-1:0] x_q, x_d;
  logic [XW-1:0] y_q, y_d;
  ph_e           ph_q, ph_d;
  logic          cfg_legal;

  // A setting is usable only with both values non-zero and X no larger than Y
  assign cfg_legal = (cfg_x != '0) && (cfg_y != '0) && (cfg_x <= cfg_y);

  // Safe points: boot, while faulted, or on an exact accumulator wrap
  assign load_o = (ph_q != PH_RUN) || wrap_i;

  always_comb begin
    x_d  = x_q;
    y_d  = y_q;
    ph_d = ph_q;
    if (load_o) begin
      x_d  = cfg_x;
      y_d  = cfg_y;
      ph_d = cfg_legal ? PH_RUN : PH_FAULT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      ph_q <= PH_BOOT;
    end else begin
      x_q  <= x_d;
      y_q  <= y_d;
      ph_q <= ph_d;
    end
  end

  assign act_x = x_q;
  assign act_y = y_q;
  assign phase = ph_q;

  // Active setting may only move while running if a wrap was seen on the prior edge
  AST_CFG_HELD_TO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_RUN) && !$stable({x_q, y_q}) |-> $past(wrap_i)); // R7

  // A running phase always carries a legal ratio
  AST_RUN_IS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN) |-> (x_q != '0) && (x_q <= y_q)); // R5

endmodule

// File: rtl/xy_rate_acc.sv
module xy_rate_acc #(
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  input  logic          run,
  input  logic [XW-1:0] act_x,
  input  logic [XW-1:0] act_y,
  output logic          hit,
  output logic          wrap
);

  localparam int SW = XW + 1;

  logic [XW-1:0] acc_q, acc_d;
  logic [SW-1:0] sum;
  logic [SW-1:0] rem;

  assign sum  = {1'b0, acc_q} + {1'b0, act_x};
  assign rem  = sum - {1'b0, act_y};
  assign hit  = step && (sum >= {1'b0, act_y});
  assign wrap = step && (sum == {1'b0, act_y});

  always_comb begin
    acc_d = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (hit) begin
      acc_d = rem[XW-1:0];
    end else if (step) begin
      acc_d = sum[XW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // Remainder stays below the denominator whenever the ratio is live
  AST_ACC_BELOW_Y: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc_q < act_y)); // R3

  // Without a step the remainder holds unless a reload clears it
  AST_ACC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clear |=> $stable(acc_q)); // R4

endmodule

// File: rtl/xy_pulse_out.sv
module xy_pulse_out #(
  parameter bit GEN_CLK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic div_en,
  output logic div_clk
);

  logic en_q, en_d;

  assign en_d = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign div_en = en_q;

  generate
    if (GEN_CLK) begin : g_tog
      logic tog_q, tog_d;

      assign tog_d = hit ? ~tog_q : tog_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tog_q <= 1'b0;
        end else begin
          tog_q <= tog_d;
        end
      end

      assign div_clk = tog_q;

      // Square wave flips only together with an enable pulse
      AST_TOGGLE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_q) |-> en_q); // R9

      AST_PULSE_FLIPS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> !$stable(tog_q)); // R9
    end else begin : g_no_tog
      assign div_clk = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/fractional_xy_div.sv
module fractional_xy_div
  import xy_div_pkg::*;
#(
  parameter int XW      = 8,
  parameter bit GEN_CLK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_en,
  input  logic [XW-1:0] cfg_x,
  input  logic [XW-1:0] cfg_y,
  output logic          div_en,
  output logic          div_clk,
  output logic          cfg_err
);

  logic [XW-1:0] act_x;
  logic [XW-1:0] act_y;
  ph_e           phase;
  logic          load;
  logic          run;
  logic          step;
  logic          hit;
  logic          wrap;

  assign run     = (phase == PH_RUN);
  assign step    = src_en && run;
  assign cfg_err = (phase == PH_FAULT);

  xy_ratio_gate #(.XW(XW)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_x  (cfg_x),
    .cfg_y  (cfg_y),
    .wrap_i (wrap),
    .act_x  (act_x),
    .act_y  (act_y),
    .phase  (phase),
    .load_o (load)
  );

  xy_rate_acc #(.XW(XW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .clear (load),
    .run   (run),
    .act_x (act_x),
    .act_y (act_y),
    .hit   (hit),
    .wrap  (wrap)
  );

  xy_pulse_out #(.GEN_CLK(GEN_CLK)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .div_en  (div_en),
    .div_clk (div_clk)
  );

  // Faulted setting suppresses every pulse
  AST_NO_PULSE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> !div_en); // R5

  // Each pulse traces back to a qualified input cycle
  AST_PULSE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |-> $past(src_en)); // R4

  // Unity ratio passes every qualified cycle straight through
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    run && (act_x == act_y) && src_en |=> div_en); // R2

  // Outputs at rest right after reset
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !div_en && !div_clk && !cfg_err); // R1

endmodule

// File: tb/fractional_xy_div_tb.sv
module fractional_xy_div_tb;

  localparam int XW = 8;
  localparam int NV = 9;
  // {x, y, steps, expected pulses}
  localparam logic [47:0] VEC [NV] = '{
    {8'd1,   8'd1,   16'd10,  16'd10},
    {8'd1,   8'd2,   16'd10,  16'd5},
    {8'd2,   8'd3,   16'd9,   16'd6},
    {8'd3,   8'd7,   16'd14,  16'd6},
    {8'd5,   8'd8,   16'd16,  16'd10},
    {8'd255, 8'd255, 16'd20,  16'd20},
    {8'd1,   8'd255, 16'd255, 16'd1},
    {8'd254, 8'd255, 16'd255, 16'd254},
    {8'd7,   8'd10,  16'd30,  16'd21}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          src_en;
  logic [XW-1:0] cx, cy, cx2, cy2;
  logic          div_en, div_clk, cfg_err;
  logic          en2, clk2, err2;

  int checks = 0;
  int fails  = 0;

  fractional_xy_div #(.XW(XW), .GEN_CLK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .cfg_x(cx), .cfg_y(cy),
    .div_en(div_en), .div_clk(div_clk), .cfg_err(cfg_err)
  );

  fractional_xy_div #(.XW(XW), .GEN_CLK(1'b1)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .src_en(div_en), .cfg_x(cx2), .cfg_y(cy2),
    .div_en(en2), .div_clk(clk2), .cfg_err(err2)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [XW-1:0] x, input logic [XW-1:0] y);
    rst_n  = 1'b0;
    src_en = 1'b0;
    cx     = x;
    cy     = y;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    int cnt;
    logic pl [64];
    cx2 = 8'd1;
    cy2 = 8'd1;

    // R1: outputs quiet during reset even with stepping requested
    rst_n = 1'b0; src_en = 1'b1; cx = 8'd1; cy = 8'd1;
    repeat (4) @(negedge clk);
    chk(!div_en && !div_clk && !cfg_err, "R1 reset state",
        {29'd0, div_en, div_clk, cfg_err}, 0);

    // R3 / R9: table of ratios walked by one loop
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v][47:40], VEC[v][39:32]);
      src_en = 1'b1;
      cnt = 0;
      for (int j = 0; j < int'(VEC[v][31:16]); j++) begin
        @(negedge clk);
        cnt += int'(div_en);
      end
      src_en = 1'b0;
      @(negedge clk);
      chk(!div_en, "R4 no pulse after src_en drops", int'(div_en), 0);
      chk(cnt == int'(VEC[v][15:0]), "R3 pulse count over Y-multiple window",
          cnt, int'(VEC[v][15:0]));
      chk(div_clk == VEC[v][0], "R9 div_clk parity", int'(div_clk), int'(VEC[v][0]));
      chk(!cfg_err, "R5 legal ratio no error", int'(cfg_err), 0);
    end

    // R10: first pulse after ceil(Y/X) steps, 1/3
    restart(8'd1, 8'd3);
    src_en = 1'b1;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      chk(div_en == (j == 3), "R10 first pulse position", int'(div_en), int'(j == 3));
    end
    src_en = 1'b0;

    // R2 / R4: gaps in src_en at unity ratio
    restart(8'd4, 8'd4);
    begin
      logic [4:0] pat;
      pat = 5'b01101;
      for (int j = 0; j < 5; j++) begin
        src_en = pat[j];
        @(negedge clk);
        chk(div_en == pat[j], "R2 R4 unity follows src_en", int'(div_en), int'(pat[j]));
      end
    end
    src_en = 1'b0;

    // R3: every sliding window of 7 steps holds 3 pulses at 3/7
    restart(8'd3, 8'd7);
    src_en = 1'b1;
    for (int j = 0; j < 50; j++) begin
      @(negedge clk);
      pl[j] = div_en;
    end
    src_en = 1'b0;
    begin
      int bad;
      int wsum;
      bad = 0;
      for (int s = 0; s + 7 <= 50; s++) begin
        wsum = 0;
        for (int k = 0; k < 7; k++) wsum += int'(pl[s + k]);
        if (wsum != 3) bad++;
      end
      chk(bad == 0, "R3 sliding windows off-count", bad, 0);
    end

    // R5: illegal settings
    restart(8'd0, 8'd5);
    chk(cfg_err, "R5 zero X flags error", int'(cfg_err), 1);
    restart(8'd3, 8'd0);
    chk(cfg_err, "R5 zero Y flags error", int'(cfg_err), 1);
    restart(8'd6, 8'd5);
    chk(cfg_err, "R5 X above Y flags error", int'(cfg_err), 1);
    src_en = 1'b1;
    cnt = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      cnt += int'(div_en);
    end
    chk(cnt == 0, "R5 no pulses while faulted", cnt, 0);

    // R6: recovery with src_en kept high
    cx = 8'd1; cy = 8'd1;
    @(negedge clk);
    chk(!cfg_err, "R6 error clears after legal write", int'(cfg_err), 0);
    chk(!div_en, "R6 no pulse on reload edge", int'(div_en), 0);
    @(negedge clk);
    chk(div_en, "R6 pulses resume", int'(div_en), 1);
    src_en = 1'b0;

    // R7: change from 1/4 to 1/2 after one step waits for wrap
    restart(8'd1, 8'd4);
    src_en = 1'b1;
    @(negedge clk);
    chk(!div_en, "R7 step1", int'(div_en), 0);
    cx = 8'd1; cy = 8'd2;
    begin
      logic [4:0] expv;
      expv = 5'b10100; // steps 2..6 -> bit index j-2
      for (int j = 2; j <= 6; j++) begin
        @(negedge clk);
        chk(div_en == expv[j-2], "R7 old ratio held until wrap",
            int'(div_en), int'(expv[j-2]));
      end
    end
    src_en = 1'b0;

    // R8: cascade 2/3 then 1/4 over 24 input steps -> 4 pulses
    cx2 = 8'd1; cy2 = 8'd4;
    restart(8'd2, 8'd3);
    src_en = 1'b1;
    cnt = 0;
    for (int j = 0; j < 28; j++) begin
      if (j == 24) src_en = 1'b0;
      @(negedge clk);
      cnt += int'(en2);
    end
    chk(cnt == 4, "R8 cascaded pulse count", cnt, 4);
    chk(!err2, "R8 downstream legal", int'(err2), 0);

    finish_run();
  end

endmodule